// File: doc/BRIEF.md
# Key-Protected Slow Clock Selector

This block produces the slow timekeeping tick for an always-on time base. It chooses between two tick strobes: one from an internal RC oscillator and one from an external crystal. The internal source goes through a fixed prescaler and then a programmable prescaler. The external source passes straight through. The output is one-cycle enable pulses in the system clock domain. A second output carries the same pulses to a pin through a gate bit.

Software uses a small register port to set three things: the source choice, the external oscillator enable and a bypass for the automatic fallback. A control write takes effect only when its upper half carries an unlock key, which guards against stray writes. A failure input from a detector outside the block forces the selection back to the internal source unless the bypass bit is set.

Source selection is a two-state machine with states `SRC_INT` and `SRC_EXT`. It has three transitions:
- `T_PICK_EXT`: a keyed write with bit 0 set, taken from `SRC_INT`.
- `T_PICK_INT`: a keyed write with bit 0 clear, taken from `SRC_EXT`.
- `T_FALLBACK`: the failure input high while the bypass bit is clear, taken from `SRC_EXT`. It has priority over any write in the same cycle.

Top module: `slow_clock_sel`

## Requirements
- R1: A write to the control register (address 0) changes no control bit unless wdata[31:16] equals 16'h16AA.
- R2: Control bit 0 picks the source: 1 selects external, 0 selects internal. The reset state is internal.
- R3: Control bits 4 (external oscillator enable) and 15 (fallback bypass) are stored on a keyed write. Reading address 0 returns bits 0, 4 and 15 in place and zero in every other bit, including the key field.
- R4: While external is selected and bit 15 is clear, a high failure input clears bit 0 on the next clock edge and the internal source is used. With bit 15 set, the failure input has no effect.
- R5: With external selected, slow_tick in each cycle equals ext_tick of the cycle before. With internal selected, slow_tick pulses only one cycle after an int_tick.
- R6: With internal selected and prescaler value P, successive slow_tick pulses are FIXED_DIV*(P+1) internal ticks apart.
- R7: The prescaler register (address 1, bits 4:0, reset 0) applies from the next divider wrap. The interval already in progress keeps the old value.
- R8: Gating register (address 2) bit 0: when set, clk_out equals slow_tick; when clear, clk_out stays low.
- R9: After reset every register reads zero and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| int_tick | input | 1 | Internal RC oscillator tick strobe |
| ext_tick | input | 1 | External crystal tick strobe |
| ext_fail | input | 1 | External oscillator failure indication |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 prescaler, 2 gating |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| slow_tick | output | 1 | Selected slow tick enable |
| clk_out | output | 1 | Gated copy of slow_tick for the output pin |

## Verification
The bench builds the block with FIXED_DIV set to 4 and keeps the 5-bit prescaler at full width. The smaller fixed divider brings every one of the 32 prescaler values into the sweep, and the measured intervals are compared with 4*(P+1) computed arithmetically. The short intervals also make it cheap to check that a prescaler change waits for the next wrap, and to run the divider with an internal tick on every other cycle. The key guard, the fallback with and without bypass, the external pass-through under a fixed bit pattern and both gate settings are each checked at the ports.

// File: rtl/slowclk_pkg.sv
package slowclk_pkg;
    typedef enum logic [1:0] {
        REG_CTRL     = 2'd0,
        REG_PRESCALE = 2'd1,
        REG_GATE     = 2'd2
    } reg_sel_e;

    typedef enum logic {
        SRC_INT = 1'b0,
        SRC_EXT = 1'b1
    } src_state_e;

    localparam logic [15:0] UNLOCK_KEY = 16'h16AA;
    localparam int SEL_BIT = 0;
    localparam int XEN_BIT = 4;
    localparam int BYP_BIT = 15;
endpackage

// File: rtl/src_select_fsm.sv
module src_select_fsm
    import slowclk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_ctrl,
    input  logic [31:0] wdata,
    input  logic        ext_fail,
    output src_state_e  state,
    output logic        ext_en,
    output logic        bypass
);
    src_state_e state_q, state_d;
    logic       en_q, byp_q;
    logic       keyed;

    assign keyed = wr_ctrl && (wdata[31:16] == UNLOCK_KEY);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SRC_INT;
        else        state_q <= state_d;
    end

    // transitions: T_PICK_EXT, T_PICK_INT, T_FALLBACK
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRC_INT: if (keyed && wdata[SEL_BIT]) state_d = SRC_EXT;
            SRC_EXT: begin
                if (ext_fail && !byp_q)            state_d = SRC_INT;
                else if (keyed && !wdata[SEL_BIT]) state_d = SRC_INT;
            end
        endcase
    end

    // keyed option bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            byp_q <= 1'b0;
        end else if (keyed) begin
            en_q  <= wdata[XEN_BIT];
            byp_q <= wdata[BYP_BIT];
        end
    end

    assign state  = state_q;
    assign ext_en = en_q;
    assign bypass = byp_q;

    AST_KEY_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wdata[31:16] != UNLOCK_KEY) |=> ($stable(en_q) && $stable(byp_q))); // R1

    AST_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SRC_EXT && ext_fail && !byp_q) |=> (state_q == SRC_INT)); // R4

    AST_BYPASS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SRC_EXT && byp_q && !keyed) |=> (state_q == SRC_EXT)); // R4
endmodule

// File: rtl/tick_divider.sv
module tick_divider #(
    parameter int FIXED_DIV = 32,
    parameter int PRE_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_tick,
    input  logic [PRE_W-1:0] pre_value,
    output logic             wrap
);
    localparam int FIX_W = (FIXED_DIV > 1) ? $clog2(FIXED_DIV) : 1;

    logic             fix_last;
    logic [PRE_W-1:0] pre_cnt, pre_act;
    logic             stage_tick;

    generate
        if (FIXED_DIV > 1) begin : g_fixed
            logic [FIX_W-1:0] fix_cnt;
            always_ff @(posedge clk) begin
                if (!rst_n)        fix_cnt <= '0;
                else if (src_tick) fix_cnt <= fix_last ? '0 : fix_cnt + 1'b1;
            end
            assign fix_last = (fix_cnt == FIX_W'(FIXED_DIV - 1));
        end else begin : g_nofixed
            assign fix_last = 1'b1;
        end
    endgenerate

    assign stage_tick = src_tick && fix_last;
    assign wrap       = stage_tick && (pre_cnt == pre_act);

    // programmable stage; new value latched on wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            pre_act <= '0;
        end else if (stage_tick) begin
            if (pre_cnt == pre_act) begin
                pre_cnt <= '0;
                pre_act <= pre_value;
            end else begin
                pre_cnt <= pre_cnt + 1'b1;
            end
        end
    end

    AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pre_cnt <= pre_act); // R6

    AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wrap) |-> $stable(pre_act)); // R7
endmodule

// File: rtl/slow_clock_sel.sv
module slow_clock_sel
    import slowclk_pkg::*;
#(
    parameter int FIXED_DIV = 32,
    parameter int PRE_W     = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        int_tick,
    input  logic        ext_tick,
    input  logic        ext_fail,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        slow_tick,
    output logic        clk_out
);
    src_state_e       state;
    logic             ext_en, bypass;
    logic             div_wrap;
    logic [PRE_W-1:0] pre_q;
    logic             gate_q;
    logic             tick_q;
    logic             wr_ctrl, wr_pre, wr_gate;

    assign wr_ctrl = reg_wr && (reg_addr == REG_CTRL);
    assign wr_pre  = reg_wr && (reg_addr == REG_PRESCALE);
    assign wr_gate = reg_wr && (reg_addr == REG_GATE);

    src_select_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctrl  (wr_ctrl),
        .wdata    (reg_wdata),
        .ext_fail (ext_fail),
        .state    (state),
        .ext_en   (ext_en),
        .bypass   (bypass)
    );

    tick_divider #(.FIXED_DIV(FIXED_DIV), .PRE_W(PRE_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_tick  (int_tick),
        .pre_value (pre_q),
        .wrap      (div_wrap)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q  <= '0;
            gate_q <= 1'b0;
        end else begin
            if (wr_pre)  pre_q  <= reg_wdata[PRE_W-1:0];
            if (wr_gate) gate_q <= reg_wdata[0];
        end
    end

    // output stage: one register after the selected source
    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= 1'b0;
        else begin
            unique case (state)
                SRC_INT: tick_q <= div_wrap;
                SRC_EXT: tick_q <= ext_tick;
            endcase
        end
    end

    assign slow_tick = tick_q;
    assign clk_out   = tick_q & gate_q;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            REG_CTRL: begin
                reg_rdata[SEL_BIT] = (state == SRC_EXT);
                reg_rdata[XEN_BIT] = ext_en;
                reg_rdata[BYP_BIT] = bypass;
            end
            REG_PRESCALE: reg_rdata[PRE_W-1:0] = pre_q;
            REG_GATE:     reg_rdata[0] = gate_q;
            default:      reg_rdata = '0;
        endcase
    end

    AST_EXT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SRC_EXT) |=> (slow_tick == $past(ext_tick))); // R5

    AST_INT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_tick && $past(state == SRC_INT)) |-> $past(int_tick)); // R5
endmodule

// File: tb/slow_clock_sel_test.sv
module slow_clock_sel_test;
    localparam int FIX = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        int_tick = 1'b0;
    logic        ext_tick = 1'b0;
    logic        ext_fail = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        slow_tick, clk_out;

    int n_chk = 0, n_bad = 0, cyc = 0, int_mode = 0;
    bit done = 0;

    slow_clock_sel #(.FIXED_DIV(FIX), .PRE_W(5)) uut (.*);

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial forever begin
        @(negedge clk);
        int_tick = (int_mode == 1) || (int_mode == 2 && !int_tick);
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic wait_pulse(output int at);
        do @(negedge clk); while (!slow_tick);
        at = cyc;
    endtask

    initial begin
        int a, b, c, cnt, bad;
        logic [31:0] v;
        logic [15:0] pat;
        logic prev;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        rd(0, v); check("R9 ctrl", v, 0);
        rd(1, v); check("R9 pre", v, 0);
        rd(2, v); check("R9 gate", v, 0);
        check("R9 out", {slow_tick, clk_out}, 0);

        // R6 full prescaler sweep
        int_mode = 1;
        for (int p = 0; p < 32; p++) begin
            wr(1, p);
            wait_pulse(a); wait_pulse(b); wait_pulse(c);
            check($sformatf("R6 P=%0d", p), c - b, FIX * (p + 1));
        end
        // R6 slower source
        int_mode = 2;
        wr(1, 5);
        wait_pulse(a); wait_pulse(b); wait_pulse(c);
        check("R6 half rate", c - b, 2 * FIX * 6);

        // R7 prescaler applies at next wrap
        int_mode = 1;
        wr(1, 3);
        wait_pulse(a); wait_pulse(a);
        wr(1, 0);
        wait_pulse(b); wait_pulse(c);
        check("R7 old interval", b - a, FIX * 4);
        check("R7 new interval", c - b, FIX * 1);

        // R8 gate
        cnt = 0; bad = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            cnt += slow_tick; bad += clk_out;
        end
        check("R8 gate off", bad, 0);
        check("R8 pulses seen", cnt > 0, 1);
        wr(2, 1);
        bad = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (clk_out !== slow_tick) bad++;
        end
        check("R8 gate on", bad, 0);

        // R1 unkeyed writes ignored
        wr(0, 32'h16AB_8011); @(negedge clk);
        rd(0, v); check("R1 wrong key", v, 0);
        wr(0, 32'h0000_0011); @(negedge clk);
        rd(0, v); check("R1 no key", v, 0);

        // R2 R3 keyed write, key field reads zero
        wr(0, 32'h16AA_0011); @(negedge clk);
        rd(0, v); check("R2 R3 keyed", v, 32'h11);

        // R5 external pass-through
        int_mode = 0;
        pat = 16'b1011_0010_1110_0101;
        prev = 1'b0;
        ext_tick = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            ext_tick = pat[i];
            prev = pat[i];
            @(negedge clk);
            check($sformatf("R5 bit %0d", i), slow_tick, prev);
        end
        ext_tick = 1'b0;

        // R4 fallback
        ext_fail = 1'b1; @(negedge clk); ext_fail = 1'b0;
        rd(0, v); check("R4 fallback", v, 32'h10);
        // R4 bypass blocks fallback
        wr(0, 32'h16AA_8011); @(negedge clk);
        ext_fail = 1'b1; @(negedge clk); ext_fail = 1'b0;
        rd(0, v); check("R4 bypass", v, 32'h8011);
        // R2 keyed return to internal
        wr(0, 32'h16AA_0000); @(negedge clk);
        rd(0, v); check("R2 back to int", v, 0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule